// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the data-moving engine of a single DMA channel. Software (or a surrounding controller) places a source address, a destination address, a transfer count, a unit size and a bus mode on the configuration inputs and pulses `start`. The sequencer then moves the programmed number of units. Each unit is a read at the current source address followed by a write of the captured data at the current destination address. After each unit both addresses step forward by the unit size.

The memory side is a plain request/acknowledge port. A request stays up until the acknowledge is seen on a clock edge. `bus_own` tells a surrounding arbiter when the channel holds the bus. In burst mode the channel keeps the bus from the first read to the last write. In cycle-steal mode it gives the bus up between units, for one cycle in the normal variant and for a fixed gap in the intermittent variant. `en` pauses the channel at a unit boundary. Three one-cycle interrupt pulses report the half-way point, the end of the job, and a rejected start caused by a misaligned address.

Top module: `dma_xfer_seq`

## Requirements
- R1: A `start` pulse while idle with a legal configuration latches all configuration inputs and sets `busy`. A `start` pulse while `busy` is high has no effect on the ongoing job.
- R2: Each unit issues a read (`mem_we`=0) at the source address, then a write (`mem_we`=1) at the destination address. The write carries the full `mem_rdata` word captured at the read acknowledge. `mem_size` shows the unit size code.
- R3: A raised request keeps its address and direction until a cycle in which `mem_ack` is high. A write request is never withdrawn before its acknowledge.
- R4: Size codes are 0=1, 1=2, 2=4, 3=16 and 4=32 bytes. After each unit, source and destination each advance by that many bytes.
- R5: A job moves exactly N units, where N is the programmed count. A count of 0 means 2^24 units.
- R6: `irq_done` pulses for one cycle after the acknowledge of the final write, and `busy` is low in that same cycle.
- R7: `irq_half` pulses for one cycle after the acknowledge of the write that completes unit floor(N/2). It never fires when N=1.
- R8: A start is rejected with a one-cycle `irq_aerr` pulse when the source or destination is not a multiple of the unit size, or when the size code is 5 to 7. A rejected start makes no memory access and leaves the channel idle. Every access made by the channel is aligned to its unit size.
- R9: In burst mode (mode code 2 or 3), `bus_own` stays high between units while `en` is high.
- R10: In normal cycle-steal mode (code 0), `bus_own` is low for exactly one cycle between units. In intermittent cycle-steal mode (code 1), it is low for exactly GAP_CYC cycles between units.
- R11: While `en` is low, no new read is requested and `bus_own` stays low at the unit boundary. A write in progress still completes. The job resumes when `en` returns high.
- R12: After reset the channel is idle, with no request, no bus ownership and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start pulse, taken only while idle |
| en | input | 1 | Channel enable; low pauses at the next read |
| cfg_src | input | ADDR_W | Source start address |
| cfg_dst | input | ADDR_W | Destination start address |
| cfg_cnt | input | CNT_W | Unit count, 0 means 2^CNT_W |
| cfg_size | input | 3 | Unit size code |
| cfg_mode | input | 2 | 0 cycle-steal, 1 intermittent cycle-steal, 2/3 burst |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Access address |
| mem_size | output | 3 | Unit size code of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack on a read |
| mem_ack | input | 1 | Access acknowledge |
| bus_own | output | 1 | Channel holds the bus |
| busy | output | 1 | Job in progress |
| irq_half | output | 1 | Half-count interrupt pulse |
| irq_done | output | 1 | End-of-job interrupt pulse |
| irq_aerr | output | 1 | Address error interrupt pulse |

## Verification
A bad address register or a wrong step shows up at the very next request as a wrong `mem_addr`. A bad data capture shows up on the write that follows the read. Both are compared against a queue of expected accesses. A corrupted unit counter shows as an interrupt that comes too early or too late, or that is missing; the half and done pulses are checked at their exact position in the access stream. A wrong state sequence shows as a wrong count of bus-release cycles between units, and that count is measured on every unit boundary.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WR   = 3'd2,
    ST_REL  = 3'd3,
    ST_GAP  = 3'd4
  } seq_state_e;

  localparam int          STEP_W    = 6;
  localparam logic [1:0]  MODE_CS   = 2'd0;
  localparam logic [1:0]  MODE_CSI  = 2'd1;

  // unit size code to byte count; illegal codes give 0
  function automatic logic [STEP_W-1:0] unit_bytes(input logic [2:0] code);
    logic [STEP_W-1:0] b;
    case (code)
      3'd0:    b = 6'd1;
      3'd1:    b = 6'd2;
      3'd2:    b = 6'd4;
      3'd3:    b = 6'd16;
      3'd4:    b = 6'd32;
      default: b = 6'd0;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dma_align_chk.sv
`timescale 1ns/1ps
module dma_align_chk
  import dma_seq_pkg::*;
(
  input  logic [STEP_W-1:0] src_lo,
  input  logic [STEP_W-1:0] dst_lo,
  input  logic [2:0]        size_code,
  output logic              aerr,
  output logic [STEP_W-1:0] step
);

  logic [STEP_W-1:0] mask;
  logic              bad_code;

  always_comb begin
    step     = unit_bytes(size_code);
    bad_code = (step == '0);
    mask     = step - STEP_W'(1);
    aerr     = bad_code || ((src_lo & mask) != '0) || ((dst_lo & mask) != '0);
  end

endmodule

// File: rtl/dma_unit_cnt.sv
`timescale 1ns/1ps
module dma_unit_cnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             dec,
  output logic             last,
  output logic             half_hit
);

  localparam int         TW  = CNT_W + 1;
  localparam logic [TW-1:0] ONE = TW'(1);
  localparam logic [TW-1:0] MAXN = ONE << CNT_W;

  logic [TW-1:0] total_q, total_d;
  logic [TW-1:0] half_q,  half_d;
  logic [TW-1:0] done_q,  done_d;
  logic [TW-1:0] done_inc;

  always_comb begin
    done_inc = done_q + ONE;
    total_d  = total_q;
    half_d   = half_q;
    done_d   = done_q;
    if (load) begin
      total_d = (cnt_in == '0) ? MAXN : {1'b0, cnt_in};
      half_d  = total_d >> 1;
      done_d  = '0;
    end else if (dec) begin
      done_d  = done_inc;
    end
    last     = dec && (done_inc == total_q);
    half_hit = dec && (done_inc == half_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      half_q  <= '0;
      done_q  <= '0;
    end else if (load || dec) begin
      total_q <= total_d;
      half_q  <= half_d;
      done_q  <= done_d;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (done_q < total_q)); // R5

endmodule

// File: rtl/dma_gap_tmr.sv
`timescale 1ns/1ps
module dma_gap_tmr #(
  parameter int GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int TW = $clog2(GAP_CYC + 1);
  localparam logic [TW-1:0] RELOAD = TW'(GAP_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    expired = (cnt_q == '0);
    cnt_en  = load || (run && !expired);
    cnt_d   = load ? RELOAD : (cnt_q - TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dma_xfer_seq.sv
`timescale 1ns/1ps
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 256,
  parameter int CNT_W   = 24,
  parameter int GAP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              en,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic [2:0]        cfg_size,
  input  logic [1:0]        cfg_mode,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [2:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              bus_own,
  output logic              busy,
  output logic              irq_half,
  output logic              irq_done,
  output logic              irq_aerr
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [DATA_W-1:0] buf_q;
  logic [2:0]        size_q, size_d;
  logic [1:0]        mode_q, mode_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              irq_half_q, irq_half_d;
  logic              irq_done_q, irq_done_d;
  logic              irq_aerr_q, irq_aerr_d;

  logic              cfg_aerr;
  logic [STEP_W-1:0] cfg_step;
  logic              cnt_load, cnt_dec, cnt_last, cnt_half;
  logic              gap_load, gap_run, gap_expired;
  logic              addr_en, rd_cap, cfg_en;

  dma_align_chk u_align (
    .src_lo    (cfg_src[STEP_W-1:0]),
    .dst_lo    (cfg_dst[STEP_W-1:0]),
    .size_code (cfg_size),
    .aerr      (cfg_aerr),
    .step      (cfg_step)
  );

  dma_unit_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (cnt_load),
    .cnt_in   (cfg_cnt),
    .dec      (cnt_dec),
    .last     (cnt_last),
    .half_hit (cnt_half)
  );

  dma_gap_tmr #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (gap_load),
    .run     (gap_run),
    .expired (gap_expired)
  );

  // next state
  always_comb begin
    state_d    = state_q;
    src_d      = src_q;
    dst_d      = dst_q;
    size_d     = size_q;
    mode_d     = mode_q;
    step_d     = step_q;
    irq_half_d = 1'b0;
    irq_done_d = 1'b0;
    irq_aerr_d = 1'b0;
    cnt_load   = 1'b0;
    cnt_dec    = 1'b0;
    gap_load   = 1'b0;
    gap_run    = 1'b0;
    addr_en    = 1'b0;
    rd_cap     = 1'b0;
    cfg_en     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (cfg_aerr) begin
            irq_aerr_d = 1'b1;
          end else begin
            cfg_en   = 1'b1;
            addr_en  = 1'b1;
            cnt_load = 1'b1;
            src_d    = cfg_src;
            dst_d    = cfg_dst;
            size_d   = cfg_size;
            mode_d   = cfg_mode;
            step_d   = cfg_step;
            state_d  = ST_RD;
          end
        end
      end
      ST_RD: begin
        if (en && mem_ack) begin
          rd_cap  = 1'b1;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (mem_ack) begin
          cnt_dec    = 1'b1;
          addr_en    = 1'b1;
          src_d      = src_q + ADDR_W'(step_q);
          dst_d      = dst_q + ADDR_W'(step_q);
          irq_half_d = cnt_half;
          if (cnt_last) begin
            irq_done_d = 1'b1;
            state_d    = ST_IDLE;
          end else if (mode_q[1]) begin
            state_d    = ST_RD;
          end else if (mode_q == MODE_CSI) begin
            gap_load   = 1'b1;
            state_d    = ST_GAP;
          end else begin
            state_d    = ST_REL;
          end
        end
      end
      ST_REL: state_d = ST_RD;
      ST_GAP: begin
        gap_run = 1'b1;
        if (gap_expired) state_d = ST_RD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= ST_IDLE;
      irq_half_q <= 1'b0;
      irq_done_q <= 1'b0;
      irq_aerr_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      irq_half_q <= irq_half_d;
      irq_done_q <= irq_done_d;
      irq_aerr_q <= irq_aerr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      size_q <= 3'd0;
      mode_q <= MODE_CS;
      step_q <= STEP_W'(1);
    end else if (cfg_en) begin
      size_q <= size_d;
      mode_q <= mode_d;
      step_q <= step_d;
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (addr_en) begin
      src_q <= src_d;
      dst_q <= dst_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_cap) buf_q <= mem_rdata;
  end

  // outputs
  always_comb begin
    busy      = (state_q != ST_IDLE);
    mem_we    = (state_q == ST_WR);
    mem_req   = ((state_q == ST_RD) && en) || mem_we;
    mem_addr  = mem_we ? dst_q : src_q;
    mem_size  = size_q;
    mem_wdata = buf_q;
    bus_own   = mem_req;
    irq_half  = irq_half_q;
    irq_done  = irq_done_q;
    irq_aerr  = irq_aerr_q;
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req && mem_we && !mem_ack) |=> (mem_req && mem_we && $stable(mem_addr))); // R3
  AST_ACCESS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_req |-> ((mem_addr[STEP_W-1:0] & (unit_bytes(mem_size) - STEP_W'(1))) == '0)); // R8
  AST_AERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_aerr |-> (!busy && !mem_req)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_done |-> !busy); // R6
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({irq_half, irq_done, irq_aerr})); // R7
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q[1] && bus_own && busy) |=> (bus_own || !busy || !en)); // R9

endmodule

// File: tb/dma_xfer_seq_tb.sv
`timescale 1ns/1ps
module dma_xfer_seq_tb_top;

  localparam int GAP = 4;
  localparam logic [2:0] K_RD = 3'd0, K_WR = 3'd1, K_HALF = 3'd2, K_DONE = 3'd3, K_AERR = 3'd4;

  typedef struct {
    logic [2:0]   kind;
    logic [31:0]  addr;
    logic [255:0] data;
    logic [2:0]   size;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         en;
  logic [31:0]  cfg_src = '0, cfg_dst = '0;
  logic [23:0]  cfg_cnt = '0;
  logic [2:0]   cfg_size = '0;
  logic [1:0]   cfg_mode = '0;
  logic         mem_req, mem_we, bus_own, busy, irq_half, irq_done, irq_aerr;
  logic [31:0]  mem_addr;
  logic [2:0]   mem_size;
  logic [255:0] mem_wdata;
  logic [255:0] mem_rdata = '0;
  logic         mem_ack = 1'b0;

  item_t exp_q[$];
  int checks = 0, bad = 0;
  int wr_seen = 0, hold_at = 0, gap_run = 0, exp_gap = 0;
  bit first_rd = 1'b1, chk_gap = 1'b1;

  assign en = (hold_at == 0) || (wr_seen < hold_at);

  always #2.5 clk = ~clk;

  dma_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .en(en),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
    .cfg_size(cfg_size), .cfg_mode(cfg_mode),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .bus_own(bus_own), .busy(busy),
    .irq_half(irq_half), .irq_done(irq_done), .irq_aerr(irq_aerr)
  );

  function automatic logic [255:0] pattern(input logic [31:0] a);
    logic [255:0] d;
    for (int i = 0; i < 8; i++) d[i*32 +: 32] = a ^ (32'h0101_0101 * (i + 1)) ^ 32'hC3C3_0000;
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic expect_evt(input logic [2:0] k, input string req);
    item_t it;
    if (exp_q.size() == 0) begin
      check(1'b0, req, "unexpected event kind", 256'(k), 256'hFF);
    end else begin
      it = exp_q.pop_front();
      check(it.kind == k, req, "event kind", 256'(k), 256'(it.kind));
    end
  endtask

  task automatic expect_access(input logic we);
    item_t it;
    logic [2:0] k;
    k = we ? K_WR : K_RD;
    if (exp_q.size() == 0) begin
      check(1'b0, "R2", "unexpected access at addr", 256'(mem_addr), 256'hFF);
    end else begin
      it = exp_q.pop_front();
      check(it.kind == k, "R2", "access kind", 256'(k), 256'(it.kind));
      check(mem_addr == it.addr, "R4", "access address", 256'(mem_addr), 256'(it.addr));
      check(mem_size == it.size, "R2", "access size", 256'(mem_size), 256'(it.size));
      if (we) check(mem_wdata == it.data, "R2", "write data", mem_wdata, it.data);
    end
  endtask

  // monitor and memory model: one access per two cycles
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      gap_run = 0;
    end else begin
      if (irq_half) expect_evt(K_HALF, "R7");
      if (irq_done) expect_evt(K_DONE, "R6");
      if (irq_aerr) expect_evt(K_AERR, "R8");
      if (busy && !bus_own) gap_run++;
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (!mem_we) begin
          mem_rdata = pattern(mem_addr);
          if (!first_rd && chk_gap)
            check(gap_run == exp_gap, exp_gap == 0 ? "R9" : "R10", "bus release cycles",
                  256'(gap_run), 256'(exp_gap));
          first_rd = 1'b0;
        end else begin
          wr_seen++;
          gap_run = 0;
        end
        expect_access(mem_we);
        mem_ack = 1'b1;
      end
    end
  end

  task automatic push(input logic [2:0] k, input logic [31:0] a, input logic [255:0] d,
                      input logic [2:0] sz);
    item_t it;
    it.kind = k; it.addr = a; it.data = d; it.size = sz;
    exp_q.push_back(it);
  endtask

  function automatic int size_bytes(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 16;
      default: return 32;
    endcase
  endfunction

  // push the expected stream for units 1..upto of a job of n units
  task automatic plan_units(input logic [31:0] s, input logic [31:0] d, input longint n,
                            input int upto, input logic [2:0] sz);
    longint h = n / 2;
    int b = size_bytes(sz);
    for (int u = 1; u <= upto; u++) begin
      logic [31:0] sa, da;
      sa = s + 32'((u - 1) * b);
      da = d + 32'((u - 1) * b);
      push(K_RD, sa, '0, sz);
      push(K_WR, da, pattern(sa), sz);
      if (u == h) push(K_HALF, '0, '0, sz);
      if (u == n) push(K_DONE, '0, '0, sz);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); #0.5;
    start = 1'b1;
    @(negedge clk); #0.5;
    start = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    int t = 0;
    while ((exp_q.size() != 0 || busy) && t < 3000) begin
      @(negedge clk); #1;
      t++;
    end
    check(exp_q.size() == 0 && !busy, req, "job finished, pending items", 256'(exp_q.size()), 256'h0);
  endtask

  task automatic run_job(input logic [31:0] s, input logic [31:0] d, input logic [23:0] n,
                         input logic [2:0] sz, input logic [1:0] md, input int gap,
                         input bit poke_busy);
    plan_units(s, d, longint'(n), int'(n), sz);
    cfg_src = s; cfg_dst = d; cfg_cnt = n; cfg_size = sz; cfg_mode = md;
    exp_gap = gap; chk_gap = 1'b1; first_rd = 1'b1; wr_seen = 0;
    pulse_start();
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      #0.5;
      cfg_src = 32'h0000_8000; cfg_dst = 32'h0000_9000; cfg_cnt = 24'd9; cfg_mode = 2'd2;
      start = 1'b1;
      @(negedge clk); #0.5;
      start = 1'b0;
      check(busy == 1'b1, "R1", "busy after start while busy", 256'(busy), 256'h1);
    end
    wait_drain("R5");
  endtask

  task automatic run_aerr(input logic [31:0] s, input logic [31:0] d, input logic [2:0] sz);
    push(K_AERR, '0, '0, sz);
    cfg_src = s; cfg_dst = d; cfg_cnt = 24'd3; cfg_size = sz; cfg_mode = 2'd2;
    pulse_start();
    repeat (4) @(negedge clk);
    #1;
    check(!busy && !mem_req, "R8", "idle and quiet after rejected start", 256'({busy, mem_req}), 256'h0);
    check(exp_q.size() == 0, "R8", "address error pulse seen", 256'(exp_q.size()), 256'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    exp_q.delete();
    hold_at = 0; wr_seen = 0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check({busy, mem_req, bus_own, irq_half, irq_done, irq_aerr} == 6'b0, "R12",
          "outputs after reset", 256'({busy, mem_req, bus_own, irq_half, irq_done, irq_aerr}), 256'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 R10: normal cycle steal, 4-byte units, start poked while busy
    run_job(32'h0000_1000, 32'h0000_2000, 24'd5, 3'd2, 2'd0, 1, 1'b1);
    // R10: intermittent cycle steal, 32-byte units
    run_job(32'h0001_0000, 32'h0002_0040, 24'd3, 3'd4, 2'd1, GAP, 1'b0);
    // R9 R4: burst, byte units at odd addresses
    run_job(32'h0000_3001, 32'h0000_4003, 24'd4, 3'd0, 2'd2, 0, 1'b0);
    // R4: burst code 3, 16-byte units
    run_job(32'h0000_5010, 32'h0000_6020, 24'd2, 3'd3, 2'd3, 0, 1'b0);
    // R7: single unit, no half pulse
    run_job(32'h0000_7002, 32'h0000_7102, 24'd1, 3'd1, 2'd0, 1, 1'b0);
    // R8: misaligned source, illegal code, misaligned destination
    run_aerr(32'h0000_1002, 32'h0000_2000, 3'd2);
    run_aerr(32'h0000_1000, 32'h0000_2000, 3'd6);
    run_aerr(32'h0000_1000, 32'h0000_2010, 3'd4);

    // R11: pause after unit 2 of a burst, then resume
    plan_units(32'h0000_A000, 32'h0000_B000, 4, 4, 3'd2);
    cfg_src = 32'h0000_A000; cfg_dst = 32'h0000_B000; cfg_cnt = 24'd4; cfg_size = 3'd2; cfg_mode = 2'd2;
    chk_gap = 1'b0; first_rd = 1'b1; wr_seen = 0; hold_at = 2;
    pulse_start();
    while (wr_seen < 2) @(negedge clk);
    repeat (8) begin
      @(negedge clk); #1;
      check(!mem_req && !bus_own && busy, "R11", "no request while disabled",
            256'({mem_req, bus_own, busy}), 256'h1);
    end
    hold_at = 0;
    wait_drain("R11");

    // R5: count 0 does not end after a few units
    plan_units(32'h0000_C000, 32'h0000_D000, 64'd16777216, 6, 3'd2);
    cfg_src = 32'h0000_C000; cfg_dst = 32'h0000_D000; cfg_cnt = 24'd0; cfg_size = 3'd2; cfg_mode = 2'd2;
    chk_gap = 1'b1; exp_gap = 0; first_rd = 1'b1; wr_seen = 0; hold_at = 6;
    pulse_start();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    #1;
    check(busy == 1'b1, "R5", "count 0 job still running", 256'(busy), 256'h1);
    do_reset();

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule